// File: doc/BRIEF.md
# Five-Limb Modular Multiplier for the Prime 2^130 - 5

This block multiplies two 130-bit operands modulo the prime p = 2^130 - 5. Each operand arrives as five limbs of radix 2^26, with limb 0 the least significant and limb 4 the most significant. The operands need not be canonical: the first operand's limbs may reach 28 bits and the second's 27 bits. This lets an accumulator plus a fresh message word, or a partly reduced key power, be fed straight back in. The caller also supplies the four values 5·g1 to 5·g4. The block uses them to fold the part of the product above 2^130 back into the low limbs, because 2^130 ≡ 5 (mod p).

The block has two pipeline registers. The first holds five 64-bit column sums of partial products. The second holds the limbs after a fixed, interleaved four-stage carry pass. That pass limits limbs 0, 2 and 3 to 26 bits and limbs 1 and 4 to 27 bits. The output is congruent to the product but is not fully reduced. A new operand pair may enter on every cycle.

Top module: `lmm_modmul`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `out_valid` is 0 and `h_out` is all zeros.
- R2: `out_valid` is 1 exactly two clock edges after a cycle with `in_valid` high, and 0 otherwise.
- R3: Limb k of each bus sits at bits [k·W +: W] of that bus, where W is the bus's limb width. With F = Σ f_k·2^(26k), G = Σ g_k·2^(26k) and H = Σ h_k·2^(26k), and with `g5_in` limb j-1 equal to 5·g_j for j = 1..4, H ≡ F·G (mod 2^130 - 5).
- R4: Output limbs 0, 2 and 3 are each below 2^26, so bit 26 of each is 0.
- R5: Output limbs 1 and 4 are each below 2^27, and no bit of the carry result above bit 26 is lost.
- R6: While `out_valid` is 0, `h_out` holds its previous value whatever the inputs do.
- R7: Operand pairs presented on consecutive cycles each produce their own result, in the same order, on consecutive cycles.
- R8: R3 and R5 hold when every f limb is 2^28 - 1 and every g limb is 2^27 - 1.
- R9: Each product term f_i·g_j with i + j ≥ 5 takes its factor from `g5_in`, never from 5·g computed inside the block. With `g5_in` all zero, H ≡ Σ over i + j < 5 of f_i·g_j·2^(26(i+j)) (mod p).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| f_in | input | 5·F_W (140) | First operand, five limbs of F_W bits |
| g_in | input | 5·G_W (135) | Second operand, five limbs of G_W bits |
| g5_in | input | 4·(G_W+3) (120) | 5·g1 to 5·g4, in that order from bit 0 |
| out_valid | output | 1 | Result present on `h_out` |
| h_out | output | 135 | Five partially reduced 27-bit result limbs |

## Verification
The two functions that can share a cycle are the carry pass on one product and the forming of partial products for the next operand pair, which happens when `in_valid` stays high on consecutive cycles. The bench provokes this by streaming three unrelated operand pairs back to back. It judges the run by checking that each result emerges on its own cycle and matches that pair's own reference product modulo p. The reference is computed from 300-bit integer values, so any leakage between the two pipeline stages shows up as a wrong congruence or a misordered result.

// File: rtl/lmm_pkg.sv
package lmm_pkg;
  localparam int LIMB_W = 26;
  localparam int NL     = 5;
  localparam int OUT_W  = LIMB_W + 1;
endpackage

// File: rtl/lmm_product.sv
// Stage 1: five column sums of partial products, with high columns
// folded through the caller-provided 5*g limbs.
module lmm_product
  import lmm_pkg::*;
#(
  parameter int F_W   = 28,
  parameter int G_W   = 27,
  parameter int ACC_W = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [NL*F_W-1:0]         f_in,
  input  logic [NL*G_W-1:0]         g_in,
  input  logic [(NL-1)*(G_W+3)-1:0] g5_in,
  output logic [NL*ACC_W-1:0]       acc_q,
  output logic                      acc_valid
);
  localparam int G5_W = G_W + 3;

  logic [F_W-1:0]   f_l  [NL];
  logic [G_W-1:0]   g_l  [NL];
  logic [G5_W-1:0]  g5_l [1:NL-1];
  logic [ACC_W-1:0] col_d [NL];

  for (genvar k = 0; k < NL; k++) begin : g_unpack
    assign f_l[k] = f_in[k*F_W +: F_W];
    assign g_l[k] = g_in[k*G_W +: G_W];
    if (k > 0) begin : g_five
      assign g5_l[k] = g5_in[(k-1)*G5_W +: G5_W];
    end
  end

  // Column k gathers f_i*g_j for i+j==k and f_i*(5g_j) for i+j==k+5.
  always_comb begin
    for (int k = 0; k < NL; k++) begin
      col_d[k] = '0;
      for (int i = 0; i < NL; i++) begin
        if (i <= k)
          col_d[k] = col_d[k] + ACC_W'(f_l[i]) * ACC_W'(g_l[k-i]);
        else
          col_d[k] = col_d[k] + ACC_W'(f_l[i]) * ACC_W'(g5_l[k-i+NL]);
      end
    end
  end

  for (genvar k = 0; k < NL; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        acc_q[k*ACC_W +: ACC_W] <= '0;
      else if (in_valid)
        acc_q[k*ACC_W +: ACC_W] <= col_d[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_valid <= 1'b0;
    else     acc_valid <= in_valid;
  end

  // R2: stage-one valid follows the input strobe by one edge
  assert_stage_valid_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> acc_valid);
  assert_stage_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !acc_valid);
endmodule

// File: rtl/lmm_carry.sv
// Stage 2: interleaved four-stage carry pass, registered.
module lmm_carry
  import lmm_pkg::*;
#(
  parameter int ACC_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_valid,
  input  logic [NL*ACC_W-1:0]   acc_in,
  output logic [NL*OUT_W-1:0]   h_out,
  output logic                  out_valid
);
  localparam logic [ACC_W-1:0] MASK = ACC_W'((64'd1 << LIMB_W) - 64'd1);

  logic [ACC_W-1:0] a_in [NL];
  logic [ACC_W-1:0] fin  [NL];

  for (genvar k = 0; k < NL; k++) begin : g_unpack
    assign a_in[k] = acc_in[k*ACC_W +: ACC_W];
  end

  always_comb begin
    logic [ACC_W-1:0] a0, a1, a2, a3, a4, ca, cb;
    a0 = a_in[0]; a1 = a_in[1]; a2 = a_in[2]; a3 = a_in[3]; a4 = a_in[4];
    // stage 1: 0 -> 1, 3 -> 4
    ca = a0 >> LIMB_W; a0 = a0 & MASK;
    cb = a3 >> LIMB_W; a3 = a3 & MASK;
    a1 = a1 + ca;      a4 = a4 + cb;
    // stage 2: 1 -> 2, 4 -> 0 (times five)
    ca = a1 >> LIMB_W; a1 = a1 & MASK;
    cb = a4 >> LIMB_W; a4 = a4 & MASK;
    a2 = a2 + ca;      a0 = a0 + (cb << 2) + cb;
    // stage 3: 0 -> 1, 2 -> 3
    ca = a0 >> LIMB_W; a0 = a0 & MASK;
    cb = a2 >> LIMB_W; a2 = a2 & MASK;
    a1 = a1 + ca;      a3 = a3 + cb;
    // stage 4: 3 -> 4
    ca = a3 >> LIMB_W; a3 = a3 & MASK;
    a4 = a4 + ca;
    fin[0] = a0; fin[1] = a1; fin[2] = a2; fin[3] = a3; fin[4] = a4;
  end

  for (genvar k = 0; k < NL; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        h_out[k*OUT_W +: OUT_W] <= '0;
      else if (acc_valid)
        h_out[k*OUT_W +: OUT_W] <= fin[k][OUT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= acc_valid;
  end

  // R2: result strobe follows the stage-one strobe
  assert_out_valid_R2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);
  assert_out_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !out_valid);
  // R5: nothing above the 27-bit output field is dropped on the wide limbs
  assert_wide_fit_R5: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> (fin[1] >> OUT_W) == '0 && (fin[4] >> OUT_W) == '0);
  // R4: narrow limbs leave the top output bit clear
  assert_narrow_limbs_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !h_out[0*OUT_W+LIMB_W] && !h_out[2*OUT_W+LIMB_W]
                  && !h_out[3*OUT_W+LIMB_W]);
  // R6: outputs hold between results
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(h_out));
endmodule

// File: rtl/lmm_modmul.sv
module lmm_modmul
  import lmm_pkg::*;
#(
  parameter int F_W   = 28,
  parameter int G_W   = 27,
  parameter int ACC_W = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [NL*F_W-1:0]         f_in,
  input  logic [NL*G_W-1:0]         g_in,
  input  logic [(NL-1)*(G_W+3)-1:0] g5_in,
  output logic                      out_valid,
  output logic [NL*OUT_W-1:0]       h_out
);
  logic [NL*ACC_W-1:0] acc;
  logic                acc_valid;

  lmm_product #(.F_W(F_W), .G_W(G_W), .ACC_W(ACC_W)) u_prod (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .f_in(f_in), .g_in(g_in), .g5_in(g5_in),
    .acc_q(acc), .acc_valid(acc_valid)
  );

  lmm_carry #(.ACC_W(ACC_W)) u_carry (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_in(acc),
    .h_out(h_out), .out_valid(out_valid)
  );

  // R1: the cycle after reset shows an idle, cleared output
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && h_out == '0);
endmodule

// File: tb/lmm_modmul_test.sv
module lmm_modmul_test;
  import lmm_pkg::*;
  localparam int F_W = 28, G_W = 27, G5_W = G_W + 3, NV = 6;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [NL*F_W-1:0]      f_in = '0;
  logic [NL*G_W-1:0]      g_in = '0;
  logic [(NL-1)*G5_W-1:0] g5_in = '0;
  logic                   out_valid;
  logic [NL*OUT_W-1:0]    h_out;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [299:0] P;

  always #4 clk = ~clk;

  lmm_modmul #(.F_W(F_W), .G_W(G_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .f_in(f_in), .g_in(g_in),
    .g5_in(g5_in), .out_valid(out_valid), .h_out(h_out));

  localparam logic [129:0] TF [NV] = '{
    130'd1, 130'd0, {130{1'b1}} - 130'd5, {130{1'b1}},
    130'h1234_5678_9abc_def0_0fed_cba9_8765_4321,
    (130'd1 << 128) | 130'hdead_beef };
  localparam logic [129:0] TG [NV] = '{
    130'd1, 130'h5555_aaaa_1234_5678_0000_ffff_cafe_f00d, {130{1'b1}} - 130'd5,
    {130{1'b1}}, 130'h0fff_0000_ffff_1234_8765_abcd_0000_ffff,
    (130'd1 << 128) | 130'h3 };

  function automatic logic [NL*F_W-1:0] pack_f(input logic [129:0] v);
    pack_f = '0;
    for (int k = 0; k < NL; k++) pack_f[k*F_W +: F_W] = F_W'(v[26*k +: 26]);
  endfunction
  function automatic logic [NL*G_W-1:0] pack_g(input logic [129:0] v);
    pack_g = '0;
    for (int k = 0; k < NL; k++) pack_g[k*G_W +: G_W] = G_W'(v[26*k +: 26]);
  endfunction
  function automatic logic [(NL-1)*G5_W-1:0] five_g(input logic [NL*G_W-1:0] g);
    five_g = '0;
    for (int j = 1; j < NL; j++)
      five_g[(j-1)*G5_W +: G5_W] = G5_W'(g[j*G_W +: G_W]) * G5_W'(5);
  endfunction
  function automatic logic [299:0] val_f(input logic [NL*F_W-1:0] f);
    val_f = '0;
    for (int k = 0; k < NL; k++) val_f = val_f + (300'(f[k*F_W +: F_W]) << (26*k));
  endfunction
  function automatic logic [299:0] val_g(input logic [NL*G_W-1:0] g);
    val_g = '0;
    for (int k = 0; k < NL; k++) val_g = val_g + (300'(g[k*G_W +: G_W]) << (26*k));
  endfunction
  function automatic logic [299:0] val_h(input logic [NL*OUT_W-1:0] h);
    val_h = '0;
    for (int k = 0; k < NL; k++) val_h = val_h + (300'(h[k*OUT_W +: OUT_W]) << (26*k));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [299:0] act,
                     input logic [299:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic judge(input logic [299:0] exp, input string req);
    logic [299:0] hv;
    hv = val_h(h_out) % P;
    chk(hv == exp, req, hv, exp);
    chk(!h_out[0*OUT_W+26] && !h_out[2*OUT_W+26] && !h_out[3*OUT_W+26],
        "R4 narrow limbs", 300'(h_out), 300'd0);
  endtask

  // drive at a falling edge, result sampled two falling edges later
  task automatic run_one(input logic [NL*F_W-1:0] f, input logic [NL*G_W-1:0] g,
                         input logic [(NL-1)*G5_W-1:0] g5,
                         input logic [299:0] exp, input string req);
    f_in = f; g_in = g; g5_in = g5; in_valid = 1;
    @(negedge clk); in_valid = 0;
    chk(out_valid == 0, "R2 early", 300'(out_valid), 300'd0);
    @(negedge clk);
    chk(out_valid == 1, "R2 latency", 300'(out_valid), 300'd1);
    judge(exp, req);
    @(negedge clk);
  endtask

  initial begin
    logic [NL*F_W-1:0] fm;
    logic [NL*G_W-1:0] gm;
    logic [299:0] e3 [3];
    logic [299:0] partial, held;
    P = (300'd1 << 130) - 300'd5;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && h_out == '0, "R1 in reset", 300'(h_out), 300'd0);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0 && h_out == '0, "R1 after reset", 300'(h_out), 300'd0);

    // table walk: R3
    for (int i = 0; i < NV; i++) begin
      fm = pack_f(TF[i]); gm = pack_g(TG[i]);
      run_one(fm, gm, five_g(gm), (val_f(fm) * val_g(gm)) % P, "R3 table product");
    end

    // R8: every limb at its maximum width
    fm = '1; gm = '1;
    run_one(fm, gm, five_g(gm), (val_f(fm) * val_g(gm)) % P, "R8 max limbs");

    // R9: fold factors come only from g5_in
    fm = pack_f(TF[4]); gm = pack_g(TG[1]);
    partial = '0;
    for (int i = 0; i < NL; i++)
      for (int j = 0; j < NL; j++)
        if (i + j < NL)
          partial = partial + ((300'(fm[i*F_W +: F_W]) * 300'(gm[j*G_W +: G_W])) << (26*(i+j)));
    run_one(fm, gm, '0, partial % P, "R9 zero fold factors");

    // R6: hold while idle with moving inputs
    held = 300'(h_out);
    for (int c = 0; c < 4; c++) begin
      f_in = pack_f(TF[c]); g_in = pack_g(TG[c+1]); g5_in = '1;
      @(negedge clk);
    end
    chk(300'(h_out) == held && out_valid == 0, "R6 hold", 300'(h_out), held);

    // R7: back-to-back stream of three pairs
    for (int s = 0; s < 3; s++) begin
      fm = pack_f(TF[s+3]); gm = pack_g(TG[5-s]);
      e3[s] = (val_f(fm) * val_g(gm)) % P;
      f_in = fm; g_in = gm; g5_in = five_g(gm); in_valid = 1;
      @(negedge clk);
      if (s >= 1) judge(e3[s-1], "R7 stream");
    end
    in_valid = 0;
    @(negedge clk);
    chk(out_valid == 1, "R7 last valid", 300'(out_valid), 300'd1);
    judge(e3[2], "R7 stream last");
    @(negedge clk);
    chk(out_valid == 0, "R2 falls", 300'(out_valid), 300'd0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule